// File: doc/BRIEF.md
# Serial Bank Window Latch

This block lets an 8-bit sound processor with a 16-bit address bus reach any 32 KB page of a host processor's 24-bit address space. The upper half of the sound processor's map (0x8000 to 0xFFFF) is a window. Each access there is translated to a host address whose low 15 bits come straight from the sound address and whose top 9 bits come from a bank base held inside the block.

The bank base is loaded serially. Software writes nine times to a single bank register. Each write contributes only data bit 0, and each successive write lands one address bit higher, starting at host bit 15. A busy flag shows that a load has started but is not yet complete. The block also decodes the local RAM region, which is 8 KB mirrored once across 0x0000 to 0x3FFF. It flags translated addresses that fall in cartridge ROM and tells the host side which byte lane of a 16-bit word is addressed.

Host arbitration and the memories themselves lie outside the block. The block only produces the addresses and select flags.

Top module: `bank_window_xlate`

## Requirements
- R1: After reset the bank base is zero and `load_busy` is 0, so a window access at 0x8000 yields host address 0x000000.
- R2: A write is taken as a bank-load write only when `cpu_addr` equals exactly 0x6000. Writes to 0x6001 to 0x60FF, and to any other address, leave the bank base and `load_busy` unchanged.
- R3: Each bank-load write uses only `cpu_wdata` bit 0. Data bits 7 to 1 have no effect.
- R4: Bank-load write number n (n = 0 to 8, counted from the start of a load) sets host address bit 15+n to the written bit, from the next cycle on.
- R5: Write number 0 of a load clears all previously accumulated base bits, so after it only host bit 15 can be 1.
- R6: `load_busy` is 1 after writes 0 to 7 of a load and returns to 0 after write 8, at which point the next write starts a new load.
- R7: When `cpu_addr[15]` is 1, `win_hit` is 1 and `host_addr` equals base*0x8000 + `cpu_addr[14:0]`. Otherwise `win_hit` is 0 and `host_addr` is 0.
- R8: `rom_sel` is 1 exactly when `win_hit` is 1 and `host_addr` is below 0x400000.
- R9: `local_sel` is 1 exactly when `cpu_addr` is below 0x4000, and `local_addr` equals `cpu_addr[12:0]`, so 0x2000 to 0x3FFF mirrors 0x0000 to 0x1FFF.
- R10: `lane_hi` is 1 exactly when `win_hit` is 1 and `cpu_addr[0]` is 0. An even host address selects the high byte of the 16-bit host word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Sound processor address |
| cpu_wdata | input | 8 | Sound processor write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| host_addr | output | 24 | Translated host address (0 outside the window) |
| win_hit | output | 1 | Access falls in the banked window |
| rom_sel | output | 1 | Translated address is in cartridge ROM |
| lane_hi | output | 1 | Window access addresses the high byte lane |
| local_sel | output | 1 | Access falls in local RAM or its mirror |
| local_addr | output | 13 | Local RAM byte address |
| load_busy | output | 1 | A serial bank load is partly done |

## Verification
The checker covers the following properties on every cycle:
- Any cycle without an exact bank-register write leaves the base and the busy flag as they were.
- The first write of a load leaves a base holding only the written bit.
- A load started from idle raises the busy flag.
- Window and local selects never overlap.
- The low host bits follow the sound address, and ROM select implies a window hit below the ROM limit.

Only the bench's scenarios can show the following:
- The full nine-write sequence and each partial base it builds.
- The counter wrapping after the ninth write.
- The disregard of the upper data bits.
- The ROM boundary at 0x3FFFFF/0x400000.

For those, the bench sweeps the sound address space under several loaded bases and compares every output with arithmetic expectations.

// File: rtl/bwl_pkg.sv
package bwl_pkg;

   // Region seen by the sound processor for one address
   typedef enum logic [1:0] {
      RGN_LOCAL  = 2'd0,
      RGN_OTHER  = 2'd1,
      RGN_BANK   = 2'd2,
      RGN_WINDOW = 2'd3
   } region_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/bwl_region_dec.sv
module bwl_region_dec
   import bwl_pkg::*;
#(
   parameter int unsigned CPU_AW        = 16,
   parameter int unsigned LOCAL_SPAN_AW = 14,
   parameter logic [CPU_AW-1:0] BANK_REG_ADDR = 16'h6000
) (
   input  logic [CPU_AW-1:0] addr,
   output region_e           region,
   output logic              local_sel,
   output logic              bank_sel,
   output logic              win_sel
);

   localparam int unsigned LOCAL_TOP = 1 << LOCAL_SPAN_AW;

   always_comb begin
      if (addr[CPU_AW-1])
         region = RGN_WINDOW;
      else if (32'(addr) < LOCAL_TOP)
         region = RGN_LOCAL;
      else if (addr == BANK_REG_ADDR)
         region = RGN_BANK;
      else
         region = RGN_OTHER;
   end

   assign local_sel = (region == RGN_LOCAL);
   assign bank_sel  = (region == RGN_BANK);
   assign win_sel   = (region == RGN_WINDOW);

endmodule

// File: rtl/bwl_bit_loader.sv
module bwl_bit_loader #(
   parameter int unsigned BASE_W = 9,
   parameter int unsigned CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              load_bit,
   output logic [BASE_W-1:0] base_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              busy_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(BASE_W - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             first_w;

   assign first_w = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_en)
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   // One flop per base bit: written on its own slot, cleared on the first slot
   for (genvar i = 0; i < BASE_W; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (load_en && (cnt_q == CNT_W'(i)))
            bit_q <= load_bit;
         else if (load_en && first_w)
            bit_q <= 1'b0;
      end
      assign base_o[i] = bit_q;
   end

   assign cnt_o  = cnt_q;
   assign busy_o = !first_w;

endmodule

// File: rtl/bwl_xlate.sv
module bwl_xlate #(
   parameter int unsigned CPU_AW       = 16,
   parameter int unsigned HOST_AW      = 24,
   parameter int unsigned WIN_AW       = 15,
   parameter logic [HOST_AW-1:0] ROM_LIMIT = 24'h400000,
   parameter bit          EVEN_IS_HIGH = 1'b1
) (
   input  logic [HOST_AW-WIN_AW-1:0] base,
   input  logic [CPU_AW-1:0]         addr,
   input  logic                      win_sel,
   output logic [HOST_AW-1:0]        host_addr,
   output logic                      rom_sel,
   output logic                      lane_hi
);

   logic [HOST_AW-1:0] raw;

   assign raw       = {base, addr[WIN_AW-1:0]};
   assign host_addr = win_sel ? raw : '0;
   assign rom_sel   = win_sel && (raw < ROM_LIMIT);

   if (EVEN_IS_HIGH) begin : g_even_high
      assign lane_hi = win_sel && !addr[0];
   end else begin : g_odd_high
      assign lane_hi = win_sel && addr[0];
   end

endmodule

// File: rtl/bank_window_xlate.sv
module bank_window_xlate
   import bwl_pkg::*;
#(
   parameter int unsigned CPU_AW        = 16,
   parameter int unsigned HOST_AW       = 24,
   parameter int unsigned WIN_AW        = 15,
   parameter int unsigned LOCAL_AW      = 13,
   parameter int unsigned LOCAL_SPAN_AW = 14,
   parameter int unsigned DATA_W        = 8,
   parameter logic [CPU_AW-1:0]  BANK_REG_ADDR = 16'h6000,
   parameter logic [HOST_AW-1:0] ROM_LIMIT     = 24'h400000,
   parameter bit          EVEN_IS_HIGH  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CPU_AW-1:0]   cpu_addr,
   input  logic [DATA_W-1:0]   cpu_wdata,
   input  logic                cpu_wr,
   output logic [HOST_AW-1:0]  host_addr,
   output logic                win_hit,
   output logic                rom_sel,
   output logic                lane_hi,
   output logic                local_sel,
   output logic [LOCAL_AW-1:0] local_addr,
   output logic                load_busy
);

   localparam int unsigned BASE_W = HOST_AW - WIN_AW;
   localparam int unsigned CNT_W  = cnt_width(BASE_W);

   // Elaboration-time parameter checks
   if (WIN_AW != CPU_AW - 1) begin : g_chk_win
      $error("window must cover the upper half of the sound address space");
   end
   if (HOST_AW <= WIN_AW + 1) begin : g_chk_host
      $error("host address must exceed window width by at least two bits");
   end
   if (LOCAL_AW > LOCAL_SPAN_AW || LOCAL_SPAN_AW >= CPU_AW - 1) begin : g_chk_local
      $error("local RAM span inconsistent with address widths");
   end

   region_e           region;
   logic              bank_sel;
   logic              win_sel;
   logic [BASE_W-1:0] bank_base;
   logic [CNT_W-1:0]  load_cnt;

   bwl_region_dec #(
      .CPU_AW        (CPU_AW),
      .LOCAL_SPAN_AW (LOCAL_SPAN_AW),
      .BANK_REG_ADDR (BANK_REG_ADDR)
   ) u_dec (
      .addr      (cpu_addr),
      .region    (region),
      .local_sel (local_sel),
      .bank_sel  (bank_sel),
      .win_sel   (win_sel)
   );

   bwl_bit_loader #(
      .BASE_W (BASE_W),
      .CNT_W  (CNT_W)
   ) u_ld (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (cpu_wr && bank_sel),
      .load_bit (cpu_wdata[0]),
      .base_o   (bank_base),
      .cnt_o    (load_cnt),
      .busy_o   (load_busy)
   );

   bwl_xlate #(
      .CPU_AW       (CPU_AW),
      .HOST_AW      (HOST_AW),
      .WIN_AW       (WIN_AW),
      .ROM_LIMIT    (ROM_LIMIT),
      .EVEN_IS_HIGH (EVEN_IS_HIGH)
   ) u_xl (
      .base      (bank_base),
      .addr      (cpu_addr),
      .win_sel   (win_sel),
      .host_addr (host_addr),
      .rom_sel   (rom_sel),
      .lane_hi   (lane_hi)
   );

   assign win_hit    = win_sel;
   assign local_addr = cpu_addr[LOCAL_AW-1:0];

endmodule

// File: rtl/bwl_checker.sv
module bwl_checker #(
   parameter int unsigned CPU_AW  = 16,
   parameter int unsigned HOST_AW = 24,
   parameter int unsigned WIN_AW  = 15,
   parameter int unsigned DATA_W  = 8,
   parameter logic [CPU_AW-1:0]  BANK_REG_ADDR = 16'h6000,
   parameter logic [HOST_AW-1:0] ROM_LIMIT     = 24'h400000
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [CPU_AW-1:0]          cpu_addr,
   input logic [DATA_W-1:0]          cpu_wdata,
   input logic                       cpu_wr,
   input logic [HOST_AW-1:0]         host_addr,
   input logic                       win_hit,
   input logic                       rom_sel,
   input logic                       local_sel,
   input logic                       load_busy,
   input logic [HOST_AW-WIN_AW-1:0]  bank_base
);

   localparam int unsigned BASE_W = HOST_AW - WIN_AW;

   logic acc;
   assign acc = cpu_wr && (cpu_addr == BANK_REG_ADDR);

   // R2: nothing but an exact bank-register write changes the load state
   a_r2_ignore_other: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> ($stable(bank_base) && $stable(load_busy)));

   // R5: the first write of a load leaves only the new bit
   a_r5_first_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !load_busy) |=> (bank_base == BASE_W'($past(cpu_wdata[0]))));

   // R6: starting a load raises busy
   a_r6_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !load_busy) |=> load_busy);

   // R7: low host bits pass through; outside the window the address is zero
   a_r7_offset: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit |-> (host_addr[WIN_AW-1:0] == cpu_addr[WIN_AW-1:0]));
   a_r7_outside: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_addr[CPU_AW-1] |-> (!win_hit && host_addr == '0));

   // R8: ROM select only inside the window and below the limit
   a_r8_rom_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rom_sel |-> (win_hit && host_addr < ROM_LIMIT));

   // R9: local RAM and window never overlap
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(local_sel && win_hit));

endmodule

bind bank_window_xlate bwl_checker #(
   .CPU_AW        (CPU_AW),
   .HOST_AW       (HOST_AW),
   .WIN_AW        (WIN_AW),
   .DATA_W        (DATA_W),
   .BANK_REG_ADDR (BANK_REG_ADDR),
   .ROM_LIMIT     (ROM_LIMIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_addr  (cpu_addr),
   .cpu_wdata (cpu_wdata),
   .cpu_wr    (cpu_wr),
   .host_addr (host_addr),
   .win_hit   (win_hit),
   .rom_sel   (rom_sel),
   .local_sel (local_sel),
   .load_busy (load_busy),
   .bank_base (bank_base)
);

// File: tb/bank_window_xlate_tb.sv
module bank_window_xlate_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_wr = 1'b0;
   logic [23:0] host_addr;
   logic        win_hit, rom_sel, lane_hi, local_sel, load_busy;
   logic [12:0] local_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // bench model of the load state
   logic [8:0] m_base = '0;
   int         m_cnt  = 0;

   always #5 clk = ~clk;

   bank_window_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .host_addr(host_addr), .win_hit(win_hit),
      .rom_sel(rom_sel), .lane_hi(lane_hi), .local_sel(local_sel),
      .local_addr(local_addr), .load_busy(load_busy)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
      if (a == 16'h6000) begin
         if (m_cnt == 0) m_base = '0;
         m_base[m_cnt] = d[0];
         m_cnt = (m_cnt == 8) ? 0 : m_cnt + 1;
      end
   endtask

   // probe state through the window
   task automatic probe_state(input string tag);
      cpu_addr = 16'h8000;
      #1;
      check({tag, " R4 base via host_addr"}, 32'(host_addr), 32'({m_base, 15'h0}));
      check({tag, " R6 busy"}, 32'(load_busy), 32'(m_cnt != 0));
   endtask

   task automatic load(input logic [8:0] v);
      for (int i = 0; i < 9; i++) begin
         // R3: junk in bits 7..1
         wr(16'h6000, {7'(8'h5B ^ 8'(i * 37)), v[i]});
         probe_state("R3/R4/R6 load step");
      end
   endtask

   task automatic check_addr(input logic [15:0] a);
      logic [23:0] eh;
      logic        ew;
      cpu_addr = a;
      #1;
      ew = a[15];
      eh = ew ? ({m_base, 15'h0} + 24'(a & 16'h7FFF)) : 24'h0;
      check("R7 win_hit", 32'(win_hit), 32'(ew));
      check("R7 host_addr", 32'(host_addr), 32'(eh));
      check("R8 rom_sel", 32'(rom_sel), 32'(ew && eh < 24'h400000));
      check("R9 local_sel", 32'(local_sel), 32'(a < 16'h4000));
      check("R9 local_addr", 32'(local_addr), 32'(a % 16'h2000));
      check("R10 lane_hi", 32'(lane_hi), 32'(ew && (a % 2 == 0)));
   endtask

   task automatic sweep();
      @(negedge clk);
      for (int a = 0; a < 65536; a += 257) check_addr(16'(a));
      check_addr(16'h1FFF); check_addr(16'h2000); check_addr(16'h3FFF);
      check_addr(16'h4000); check_addr(16'h7FFF); check_addr(16'h8000);
      check_addr(16'h8001); check_addr(16'hFFFF); check_addr(16'hFFFE);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      probe_state("R1 reset");
      check("R1 reset win_hit", 32'(win_hit), 32'd1);

      // main loads with sweeps
      load(9'h1FF); sweep();
      load(9'h0AB); sweep();
      load(9'h007); sweep();
      load(9'h07F); check_addr(16'hFFFF);            // R8 0x3FFFFF -> ROM
      load(9'h080); check_addr(16'h8000);            // R8 0x400000 -> not ROM
      load(9'h155); sweep();

      // R5: new load clears previous base after first write
      load(9'h1FF);
      wr(16'h6000, 8'hFE);                           // bit 0 = 0
      probe_state("R5 first write clears");
      wr(16'h6000, 8'h01);
      probe_state("R5 second write");

      // R2: ignored writes mid-load
      wr(16'h6001, 8'hFF); probe_state("R2 0x6001 ignored");
      wr(16'h60FF, 8'hFF); probe_state("R2 0x60FF ignored");
      wr(16'h6100, 8'hFF); probe_state("R2 0x6100 ignored");
      wr(16'h5FFF, 8'hFF); probe_state("R2 0x5FFF ignored");
      wr(16'hE000, 8'hFF); probe_state("R2 window write ignored");
      wr(16'h2000, 8'hFF); probe_state("R2 local write ignored");

      // finish the load, then R6 wrap: next write starts afresh
      for (int i = 0; i < 7; i++) wr(16'h6000, 8'h01);
      probe_state("R6 wrap after ninth");
      check("R6 busy low after nine", 32'(load_busy), 32'd0);
      wr(16'h6000, 8'h01);
      probe_state("R6 restart");
      sweep();

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule